// File: doc/BRIEF.md
# Refresh Counter Self-Test Sequencer

This block is a built-in test engine for an asynchronous DRAM with a four-bit data path and an on-chip refresh row counter. After a start pulse it drives the strobe, write-enable, output-enable, address and data pins through a fixed sequence. The goal is to prove that the memory's internal refresh counter visits every row exactly once. The whole test uses one fixed column. First the counter is woken with a short burst of row-only refresh cycles. Then every row receives a background pattern through ordinary early-write cycles, where the sequencer supplies the row. Next comes one counter-addressed read-modify-write per row: column strobe low before row strobe, then a second column fall that latches only the column. A normal read pass checks every row for the complement. The write, counter and read passes then repeat with the background inverted.

Each pin step lasts a whole number of clocks, derived from the clock period and the minimum strobe width. The sequencer compares read data at the end of each sampling step. It keeps a shadow row index so that the first mismatch can be reported with its pass, phase and index. In the counter phase, the index is the ordinal of the counter-test cycle, not a row the sequencer ever drives.

Top module: `rcst_top`

## Requirements
- R1: In reset, and while idle, ras_n, cas_n, we_n and oe_n are high, dq_oe is low, and busy, done and fail are low.
- R2: A run starts with INIT_CYC (default 8) row-only refresh cycles, where the row strobe is pulsed while the column strobe stays high; no other row-only refresh cycle occurs during the run.
- R3: In each write phase every row 0..ROWS-1 gets one early write, with we_n low before the column strobe falls, at column TEST_COL. The data is the current background, and data is driven only while we_n is low, oe_n is high and the column strobe is low.
- R4: Each counter-test cycle drops the column strobe before the row strobe, with we_n high both at and one clock before the row strobe fall, so test mode is never entered. It then raises and lowers the column strobe again with TEST_COL on the address pins; there is exactly one such cycle per row per pass.
- R5: Each counter-test cycle reads the cell, compares it with the background, and writes the complement through a we_n fall while the column strobe is low and oe_n is high.
- R6: In each verify phase, every row is read with a normal read cycle and compared with the complement of the background.
- R7: The second pass uses the inverted background, so a clean run leaves every row at column TEST_COL holding PATTERN.
- R8: done rises, and busy falls, exactly STEP_CYC*(4*INIT_CYC + 36*ROWS) clocks after the clock edge that accepts start. done then holds until the next start.
- R9: The first mismatch sets fail and records fail_phase (1 = counter test, 2 = verify), fail_pass (0 = first pass, 1 = inverted pass) and fail_index (the row, or the counter-test cycle ordinal). These hold until the next accepted start.
- R10: Every column-strobe low pulse lasts at least STEP_MIN_NS, and each pin step lasts exactly STEP_CYC clocks, with STEP_CYC = max(2, ceil(STEP_MIN_NS/CLK_PERIOD_NS)).
- R11: start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, accepted when not busy |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | ROW_BITS | Multiplexed row/column address |
| dq_out | output | DQ_W | Write data |
| dq_oe | output | 1 | Write data drive enable |
| dq_in | input | DQ_W | Read data from the memory |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished |
| fail | output | 1 | A mismatch was seen |
| fail_phase | output | 2 | Phase of the first mismatch |
| fail_pass | output | 1 | Pass of the first mismatch |
| fail_index | output | ROW_BITS | Row or cycle ordinal of the first mismatch |

## Verification
In the counter phase, the compare of the read data and the write of the complement fall in the same row cycle. Their order matters: a fault must be reported against the data read before the write. The bench provokes this with a stuck-at-1 bit on a randomly chosen row, which must fail in the counter phase at the ordinal (row - counter start) mod ROWS. It also uses a stuck-at-0 bit that hides during the compare and is caught only in the verify read at the row itself. A start pulse placed at a random point while busy checks that a new request and a running sequence never combine: the end time and the results of that run stay unchanged.

// File: rtl/rcst_pkg.sv
package rcst_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_INIT, PH_WRITE, PH_CTEST, PH_VERIFY, PH_DONE
  } phase_t;

  // one pin step: strobe levels, address select, data drive, compare point, end of cycle
  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
    logic use_col;
    logic drive;
    logic sample;
    logic last;
  } pinstep_t;

  function automatic pinstep_t mk(logic r, logic c, logic w, logic o,
                                  logic col, logic d, logic s, logic l);
    pinstep_t p;
    p.ras_n = r; p.cas_n = c; p.we_n = w; p.oe_n = o;
    p.use_col = col; p.drive = d; p.sample = s; p.last = l;
    return p;
  endfunction

  function automatic pinstep_t step_pins(phase_t ph, logic [2:0] st);
    pinstep_t p = mk(1, 1, 1, 1, 0, 0, 0, 0);
    case (ph)
      PH_INIT: case (st)
        3'd1, 3'd2: p = mk(0, 1, 1, 1, 0, 0, 0, 0);
        3'd3:       p = mk(1, 1, 1, 1, 0, 0, 0, 1);
        default:    p = mk(1, 1, 1, 1, 0, 0, 0, 0);
      endcase
      PH_WRITE: case (st)
        3'd0:       p = mk(1, 1, 0, 1, 0, 0, 0, 0);
        3'd1:       p = mk(0, 1, 0, 1, 0, 0, 0, 0);
        3'd2, 3'd3: p = mk(0, 0, 0, 1, 1, 1, 0, 0);
        default:    p = mk(1, 1, 1, 1, 1, 0, 0, 1);
      endcase
      PH_CTEST: case (st)
        3'd0:       p = mk(1, 0, 1, 1, 1, 0, 0, 0);
        3'd1:       p = mk(0, 0, 1, 1, 1, 0, 0, 0);
        3'd2:       p = mk(0, 1, 1, 1, 1, 0, 0, 0);
        3'd3:       p = mk(0, 0, 1, 0, 1, 0, 0, 0);
        3'd4:       p = mk(0, 0, 1, 0, 1, 0, 1, 0);
        3'd5, 3'd6: p = mk(0, 0, 0, 1, 1, 1, 0, 0);
        default:    p = mk(1, 1, 1, 1, 1, 0, 0, 1);
      endcase
      PH_VERIFY: case (st)
        3'd0:       p = mk(1, 1, 1, 1, 0, 0, 0, 0);
        3'd1:       p = mk(0, 1, 1, 1, 0, 0, 0, 0);
        3'd2:       p = mk(0, 0, 1, 0, 1, 0, 0, 0);
        3'd3:       p = mk(0, 0, 1, 0, 1, 0, 1, 0);
        default:    p = mk(1, 1, 1, 1, 1, 0, 0, 1);
      endcase
      default: p = mk(1, 1, 1, 1, 0, 0, 0, 0);
    endcase
    return p;
  endfunction

  function automatic phase_t next_phase(phase_t ph, logic pass);
    case (ph)
      PH_INIT:  return PH_WRITE;
      PH_WRITE: return PH_CTEST;
      PH_CTEST: return PH_VERIFY;
      PH_VERIFY: return pass ? PH_DONE : PH_WRITE;
      default:  return PH_IDLE;
    endcase
  endfunction

  function automatic int step_cycles(int min_ns, int clk_ns);
    int raw = (min_ns + clk_ns - 1) / clk_ns;
    return (raw < 2) ? 2 : raw;
  endfunction

endpackage

// File: rtl/rcst_step_timer.sv
module rcst_step_timer #(
  parameter int STEP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick_last
);
  localparam int CW = $clog2(STEP_CYC) + 1;
  logic [CW-1:0] cnt;

  assign tick_last = run && (cnt == CW'(STEP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || tick_last) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R10: a step never outlives its clock budget
  a_r10_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(STEP_CYC));
endmodule

// File: rtl/rcst_row_walker.sv
module rcst_row_walker #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [IDX_W-1:0] limit,
  output logic [IDX_W-1:0] idx,
  output logic             idx_last
);
  assign idx_last = (idx == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clear)   idx <= '0;
    else if (advance) idx <= idx_last ? '0 : idx + 1'b1;
  end

  // R2/R3: the shadow index stays inside the current phase's range
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= limit);
endmodule

// File: rtl/rcst_result_keeper.sv
module rcst_result_keeper #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             check,
  input  logic             mismatch,
  input  logic [1:0]       phase_code,
  input  logic             pass,
  input  logic [IDX_W-1:0] idx,
  output logic             fail,
  output logic [1:0]       fail_phase,
  output logic             fail_pass,
  output logic [IDX_W-1:0] fail_index
);
  logic first_miss;
  assign first_miss = check && mismatch && !fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clear) begin
      fail <= 1'b0; fail_phase <= 2'd0; fail_pass <= 1'b0; fail_index <= '0;
    end else if (first_miss) begin
      fail <= 1'b1; fail_phase <= phase_code; fail_pass <= pass; fail_index <= idx;
    end
  end

  // R9: the first record is sticky until a new run clears it
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> (fail && $stable(fail_index) && $stable(fail_phase)));
endmodule

// File: rtl/rcst_top.sv
module rcst_top #(
  parameter int ROW_BITS      = 10,
  parameter int DQ_W          = 4,
  parameter int TEST_COL      = 341,
  parameter int PATTERN       = 10,
  parameter int INIT_CYC      = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int STEP_MIN_NS   = 35
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                oe_n,
  output logic [ROW_BITS-1:0] addr,
  output logic [DQ_W-1:0]     dq_out,
  output logic                dq_oe,
  input  logic [DQ_W-1:0]     dq_in,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [1:0]          fail_phase,
  output logic                fail_pass,
  output logic [ROW_BITS-1:0] fail_index
);
  import rcst_pkg::*;

  localparam int ROWS     = 1 << ROW_BITS;
  localparam int STEP_CYC = step_cycles(STEP_MIN_NS, CLK_PERIOD_NS);
  localparam logic [ROW_BITS-1:0] COL_ADDR  = ROW_BITS'(TEST_COL);
  localparam logic [ROW_BITS-1:0] ROW_LIM   = ROW_BITS'(ROWS - 1);
  localparam logic [ROW_BITS-1:0] INIT_LIM  = ROW_BITS'(INIT_CYC - 1);
  localparam logic [DQ_W-1:0]     BG0       = DQ_W'(PATTERN);

  phase_t        phase;
  logic [2:0]    step;
  logic          pass;
  pinstep_t      cur;
  logic          run, tick_last, step_end, cycle_end, accept;
  logic [ROW_BITS-1:0] idx, limit;
  logic          idx_last;
  logic [DQ_W-1:0] bg, expect_rd;

  // named internal events
  assign run       = (phase != PH_IDLE) && (phase != PH_DONE);
  assign accept    = start && !run;
  assign cur       = step_pins(phase, step);
  assign step_end  = run && tick_last;
  assign cycle_end = step_end && cur.last;
  assign limit     = (phase == PH_INIT) ? INIT_LIM : ROW_LIM;

  // data arithmetic
  assign bg        = pass ? ~BG0 : BG0;
  assign expect_rd = (phase == PH_CTEST) ? bg : ~bg;
  assign dq_out    = (phase == PH_WRITE) ? bg : ~bg;

  assign ras_n = cur.ras_n;
  assign cas_n = cur.cas_n;
  assign we_n  = cur.we_n;
  assign oe_n  = cur.oe_n;
  assign dq_oe = cur.drive;
  assign addr  = cur.use_col ? COL_ADDR : idx;
  assign busy  = run;
  assign done  = (phase == PH_DONE);

  rcst_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_last(tick_last));

  rcst_row_walker #(.IDX_W(ROW_BITS)) u_walker (
    .clk(clk), .rst_n(rst_n), .clear(accept), .advance(cycle_end),
    .limit(limit), .idx(idx), .idx_last(idx_last));

  rcst_result_keeper #(.IDX_W(ROW_BITS)) u_keeper (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .check(step_end && cur.sample), .mismatch(dq_in != expect_rd),
    .phase_code((phase == PH_CTEST) ? 2'd1 : 2'd2), .pass(pass), .idx(idx),
    .fail(fail), .fail_phase(fail_phase), .fail_pass(fail_pass),
    .fail_index(fail_index));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; step <= 3'd0; pass <= 1'b0;
    end else if (accept) begin
      phase <= PH_INIT; step <= 3'd0; pass <= 1'b0;
    end else if (step_end) begin
      if (cur.last) begin
        step <= 3'd0;
        if (idx_last) begin
          phase <= next_phase(phase, pass);
          if (phase == PH_VERIFY) pass <= 1'b1;
        end
      end else begin
        step <= step + 3'd1;
      end
    end
  end

  // R4: write enable high at and before every CAS-before-RAS row fall
  a_r4_no_test_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> (we_n && $past(we_n)));
  // R10: a column strobe fall lasts more than one clock
  a_r10_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |=> !cas_n);
  // R3: data drive only in the write window
  a_r3_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && oe_n && !cas_n && !ras_n));
  // R8: a finished sequence leaves the pins quiet
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && ras_n && cas_n && we_n));
  // R11: start during a run changes nothing about the phase walk
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !step_end) |=> ($stable(step) && $stable(phase)));
endmodule

// File: tb/rcst_top_test.sv
module rcst_top_test;
  localparam int CLK_NS = 10;
  localparam int RB     = 6;
  localparam int ROWS   = 1 << RB;
  localparam int COL    = 43;
  localparam int PAT    = 10;
  localparam int STEPC  = 4;
  localparam int TOTAL  = STEPC * (4 * 8 + 36 * ROWS);

  logic clk = 0, rst_n = 0, start = 0;
  logic ras_n, cas_n, we_n, oe_n, dq_oe, busy, done, fail, fail_pass;
  logic [RB-1:0] addr, fail_index;
  logic [3:0] dq_out, dq_in;
  logic [1:0] fail_phase;
  int checks = 0, failures = 0;

  always #(CLK_NS/2) clk = ~clk;

  rcst_top #(.ROW_BITS(RB), .DQ_W(4), .TEST_COL(COL), .PATTERN(PAT), .INIT_CYC(8),
             .CLK_PERIOD_NS(CLK_NS), .STEP_MIN_NS(35)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_in(dq_in), .busy(busy), .done(done), .fail(fail), .fail_phase(fail_phase),
    .fail_pass(fail_pass), .fail_index(fail_index));

  // behavioural memory: one column, internal refresh counter, fault hooks
  logic [3:0] mem [ROWS];
  logic [RB-1:0] rc, row;
  logic p_ras = 1, p_cas = 1, p_we = 1, cbr = 0, act = 0, ronly = 0;
  int n_ronly, n_cbr, n_tm, n_colerr, n_early, cas_w, cas_min;
  int fault_mode = 0;
  logic [RB-1:0] fault_row;

  function automatic logic [3:0] faulted(logic [RB-1:0] r, logic [3:0] d);
    if (fault_mode == 1 && r == fault_row) return d | 4'b0001;
    if (fault_mode == 2 && r == fault_row) return d & 4'b1110;
    return d;
  endfunction

  assign dq_in = (act && !ras_n && !cas_n && !oe_n && we_n) ? mem[row] : 4'h0;

  always @(negedge clk) begin
    if (!cas_n) cas_w = cas_w + 1;
    if (cas_n && !p_cas && cas_w < cas_min) cas_min = cas_w;
    if (cas_n) cas_w = 0;
    if (!ras_n && p_ras) begin
      if (!cas_n) begin
        cbr = 1; row = rc; rc = rc + 1'b1; n_cbr++;
        if (!we_n) n_tm++;
      end else begin
        cbr = 0; row = addr; ronly = 1;
      end
    end
    if (!cas_n && p_cas && !ras_n) begin
      ronly = 0; act = 1;
      if (addr != RB'(COL)) n_colerr++;
      if (!cbr && !we_n) begin mem[row] = faulted(row, dq_out); n_early++; end
    end
    if (cas_n && !p_cas) act = 0;
    if (!we_n && p_we && act && !cas_n && !ras_n) mem[row] = faulted(row, dq_out);
    if (ras_n && !p_ras) begin
      if (ronly) n_ronly++;
      ronly = 0; cbr = 0; act = 0;
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n;
  end

  task automatic chk(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // runs one sequence; returns cycles to done (or -1 on watchdog)
  task automatic run_seq(input int poke_at, output int cyc);
    n_ronly = 0; n_cbr = 0; n_tm = 0; n_colerr = 0; n_early = 0;
    cas_w = 0; cas_min = 1000;
    @(negedge clk); start = 1;
    @(posedge clk); @(negedge clk); start = 0;
    cyc = 0;
    for (int k = 0; k < 4 * TOTAL; k++) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      start = (cyc == poke_at);
      if (done) break;
    end
    start = 0;
    if (!done) begin
      failures++; $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, TOTAL); cyc = -1;
    end
  endtask

  function automatic int exp_ord(int frow, int rc0);
    return (frow - rc0 + ROWS) % ROWS;
  endfunction

  initial begin
    int cyc, rc0, bad;
    void'($urandom(20240611));
    rc = RB'($urandom);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pins", {ras_n, cas_n, we_n, oe_n, dq_oe}, 5'b11110);
    chk("R1 status", {busy, done, fail}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle", {ras_n, cas_n, busy, done}, 4'b1100);

    // clean run with a start poke while busy
    rc = RB'($urandom);
    run_seq(100 + int'($urandom % 2000), cyc);
    chk("R8 latency", cyc, TOTAL);
    chk("R11 busy low at done", busy, 0);
    chk("R2 row-only count", n_ronly, 8);
    chk("R3 early writes", n_early, 2 * ROWS);
    chk("R4 counter cycles", n_cbr, 2 * ROWS);
    chk("R4 test mode entries", n_tm, 0);
    chk("R4 column latch", n_colerr, 0);
    chk("R10 cas width", (cas_min * CLK_NS >= 35) ? 1 : 0, 1);
    chk("R5 R6 no fail", fail, 0);
    bad = 0;
    for (int r = 0; r < ROWS; r++) if (mem[r] != 4'(PAT)) bad++;
    chk("R7 final pattern", bad, 0);
    repeat (5) @(negedge clk);
    chk("R8 done holds", done, 1);

    // stuck-at-1 bit: caught by counter-addressed compare, restart from done
    fault_mode = 1; fault_row = RB'($urandom);
    rc = RB'($urandom); rc0 = int'(rc);
    run_seq(-1, cyc);
    chk("R9 ctest fail", fail, 1);
    chk("R5 fail phase", fail_phase, 1);
    chk("R9 fail pass", fail_pass, 0);
    chk("R5 counter ordinal", fail_index, exp_ord(int'(fault_row), rc0));

    // stuck-at-0 bit: hidden from compare, caught by verify read
    rst_n = 0; repeat (2) @(negedge clk);
    chk("R1 reset clears fail", fail, 0);
    rst_n = 1;
    fault_mode = 2; fault_row = RB'($urandom);
    rc = RB'($urandom);
    run_seq(-1, cyc);
    chk("R6 verify fail", fail_phase, 2);
    chk("R6 fail row", fail_index, int'(fault_row));
    chk("R9 fail pass 0", fail_pass, 0);
    repeat (3) @(negedge clk);
    chk("R9 sticky", {fail, fail_index}, {1'b1, fault_row});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule